// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Sequencer

This block is the processor-facing half of an eight-level interrupt controller. It watches an active-low acknowledge line and an active-low read strobe, and it drives an 8-bit data bus with an output enable. The acknowledge handshake has two pulses. On the first falling edge the block tells the neighbouring priority logic to move the winning pending level into service, and it records that level. On the second falling edge it places the vector byte on the bus. The vector is the programmed base in the upper five bits and the recorded level in the lower three.

The block also answers ordinary register reads. An even-address read returns either the in-service or the request register, depending on the most recent read-select command. An odd-address read returns the mask. After a poll command, the next even-address read is an alternative to the two-pulse handshake: it returns a pending flag and the winning level, and it commits that level into service in the same way as a first acknowledge pulse.

Every strobe is sampled on the block clock. Bus contents are captured at the falling edge of the strobe and held until the strobe rises.

Top module: `iav_ack_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `bus_oe` and `svc_commit` are low, the acknowledge count is idle and no poll is armed. Even-address reads return the in-service register until a read-select command says otherwise.
- R2: When `inta_n` falls while the count is idle and `pend_valid` is high, `svc_commit` is high for exactly one cycle and `svc_level` equals `pend_level` as sampled at that edge. `bus_oe` stays low.
- R3: When `inta_n` falls for the second time, `bus_oe` rises the next cycle and `bus_data` equals `{vec_base, L}`, where L is the level recorded at the first fall. Later changes of `pend_level` do not affect L.
- R4: If `pend_valid` is low at the first fall, `svc_commit` stays low and the second pulse returns `{vec_base, 3'b111}`.
- R5: A `rsel_we` pulse stores `rsel_irr`. An even-address read (`addr_odd`=0) with no poll armed returns `irr` when the stored value is 1 and `isr` when it is 0.
- R6: An odd-address read (`addr_odd`=1) returns `imr` and leaves an armed poll in place.
- R7: After a `poll_cmd` pulse, the next even-address read returns `8'h80 | level` and commits that level if a request is pending. If none is pending it returns `8'h00` and does not commit. In either case the poll is cleared, so the following even read returns a register again.
- R8: `bus_oe` rises only in the cycle after a second-acknowledge fall or a read-strobe fall. It falls in the cycle after that strobe rises. The first acknowledge pulse never drives the bus.
- R9: The count returns to idle when the second pulse rises, and also on reset. A following acknowledge pulse then acts as a new first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inta_n | input | 1 | Active-low interrupt acknowledge from the processor |
| rd_n | input | 1 | Active-low read strobe |
| addr_odd | input | 1 | Address bit 0 of the read; 1 selects the mask |
| pend_valid | input | 1 | A request is pending in the priority logic |
| pend_level | input | 3 | Winning pending level from the priority logic |
| vec_base | input | 5 | Programmed vector base, upper five bits of the vector |
| isr | input | 8 | In-service register, for readback |
| irr | input | 8 | Request register, for readback |
| imr | input | 8 | Mask register, for readback |
| rsel_we | input | 1 | One-cycle read-select command strobe |
| rsel_irr | input | 1 | Read-select value: 1 = request register, 0 = in-service |
| poll_cmd | input | 1 | One-cycle poll command strobe |
| svc_commit | output | 1 | One-cycle request to move `svc_level` into service |
| svc_level | output | 3 | Level to commit into service |
| bus_data | output | 8 | Byte driven onto the processor data bus |
| bus_oe | output | 1 | Output enable for `bus_data` |

## Verification
The assertions assume that `inta_n` and `rd_n` are already synchronous to `clk`, that each low or high phase lasts at least one clock, and that the two strobes never fall in the same cycle. They also assume `pend_level` is meaningful only while `pend_valid` is high. The bench changes every input on the falling clock edge and keeps each strobe phase at least one full cycle long. It never overlaps an acknowledge pulse with a read, and it holds both strobes high across reset, so every edge the block sees is a clean, isolated one.

// File: rtl/iav_pkg.sv
package iav_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LVL_W  = 3;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_ARMED = 2'd1,
    ACK_DRIVE = 2'd2
  } ack_phase_e;
endpackage

// File: rtl/iav_strobe_edge.sv
module iav_strobe_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strb_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b1;
      else        prev_q[g] <= strb_n[g];
    end
    assign fall[g] = prev_q[g] & ~strb_n[g];
    assign rise[g] = ~prev_q[g] & strb_n[g];
  end
endmodule

// File: rtl/iav_ack_fsm.sv
module iav_ack_fsm
  import iav_pkg::*;
#(
  parameter int unsigned LVL_W = iav_pkg::LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_fall,
  input  logic             ack_rise,
  input  logic             poll_take,
  input  logic             pend_valid,
  input  logic [LVL_W-1:0] pend_level,
  output logic             commit,
  output logic [LVL_W-1:0] commit_level,
  output logic [LVL_W-1:0] vec_level,
  output logic             vec_start
);
  localparam logic [LVL_W-1:0] SPUR_LVL = {LVL_W{1'b1}};

  ack_phase_e       phase_q, phase_n;
  logic [LVL_W-1:0] lvl_q, lvl_n;
  logic             commit_q, commit_n;
  logic [LVL_W-1:0] clvl_q, clvl_n;

  always_comb begin
    phase_n  = phase_q;
    lvl_n    = lvl_q;
    commit_n = 1'b0;
    clvl_n   = clvl_q;
    case (phase_q)
      ACK_IDLE: if (ack_fall) begin
        phase_n  = ACK_ARMED;
        lvl_n    = pend_valid ? pend_level : SPUR_LVL;
        commit_n = pend_valid;
        clvl_n   = pend_level;
      end
      ACK_ARMED: if (ack_fall) phase_n = ACK_DRIVE;
      ACK_DRIVE: if (ack_rise) phase_n = ACK_IDLE;
      default:   phase_n = ACK_IDLE;
    endcase
    if (poll_take) begin
      commit_n = pend_valid;
      clvl_n   = pend_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= ACK_IDLE;
      lvl_q    <= '0;
      commit_q <= 1'b0;
      clvl_q   <= '0;
    end else begin
      phase_q  <= phase_n;
      lvl_q    <= lvl_n;
      commit_q <= commit_n;
      clvl_q   <= clvl_n;
    end
  end

  assign commit       = commit_q;
  assign commit_level = clvl_q;
  assign vec_level    = lvl_q;
  assign vec_start    = ack_fall && (phase_q == ACK_ARMED);

  // R2: a commit only ever follows a cycle in which a request was pending
  p_commit_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(pend_valid));

  // R4: first pulse with nothing pending yields the spurious level, no commit
  p_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && phase_q == ACK_IDLE && !pend_valid && !poll_take)
      |=> (!commit && vec_level == SPUR_LVL));

  // R9: end of the second pulse returns the count to idle
  p_drive_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ACK_DRIVE && ack_rise) |=> (phase_q == ACK_IDLE));
endmodule

// File: rtl/iav_read_mux.sv
module iav_read_mux #(
  parameter int unsigned DATA_W = iav_pkg::DATA_W,
  parameter int unsigned LVL_W  = iav_pkg::LVL_W
) (
  input  logic              addr_odd,
  input  logic              poll_arm,
  input  logic              rsel_irr,
  input  logic [DATA_W-1:0] isr,
  input  logic [DATA_W-1:0] irr,
  input  logic [DATA_W-1:0] imr,
  input  logic              pend_valid,
  input  logic [LVL_W-1:0]  pend_level,
  output logic [DATA_W-1:0] rd_byte
);
  always_comb begin
    rd_byte = '0;
    if (addr_odd) begin
      rd_byte = imr;
    end else if (poll_arm) begin
      if (pend_valid) begin
        rd_byte[DATA_W-1]  = 1'b1;
        rd_byte[LVL_W-1:0] = pend_level;
      end
    end else begin
      rd_byte = rsel_irr ? irr : isr;
    end
  end
endmodule

// File: rtl/iav_ack_seq.sv
module iav_ack_seq #(
  parameter int unsigned DATA_W = iav_pkg::DATA_W,
  parameter int unsigned LVL_W  = iav_pkg::LVL_W,
  localparam int unsigned BASE_W = DATA_W - LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inta_n,
  input  logic              rd_n,
  input  logic              addr_odd,
  input  logic              pend_valid,
  input  logic [LVL_W-1:0]  pend_level,
  input  logic [BASE_W-1:0] vec_base,
  input  logic [DATA_W-1:0] isr,
  input  logic [DATA_W-1:0] irr,
  input  logic [DATA_W-1:0] imr,
  input  logic              rsel_we,
  input  logic              rsel_irr,
  input  logic              poll_cmd,
  output logic              svc_commit,
  output logic [LVL_W-1:0]  svc_level,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe
);
  logic [1:0] fall, rise;
  logic       ack_fall, ack_rise, rd_fall, rd_rise;
  logic       rd_go, poll_take, vec_start;
  logic [LVL_W-1:0]  vec_level;
  logic [DATA_W-1:0] rd_byte;

  logic              poll_q, poll_n;
  logic              rsel_q, rsel_n;
  logic              oe_q, oe_n;
  logic [DATA_W-1:0] data_q, data_n;

  iav_strobe_edge #(.N(2)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb_n ({rd_n, inta_n}),
    .fall   (fall),
    .rise   (rise)
  );

  assign ack_fall  = fall[0];
  assign ack_rise  = rise[0];
  assign rd_fall   = fall[1];
  assign rd_rise   = rise[1];
  assign rd_go     = rd_fall & ~ack_fall;
  assign poll_take = rd_go & ~addr_odd & poll_q;

  iav_ack_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_fall     (ack_fall),
    .ack_rise     (ack_rise),
    .poll_take    (poll_take),
    .pend_valid   (pend_valid),
    .pend_level   (pend_level),
    .commit       (svc_commit),
    .commit_level (svc_level),
    .vec_level    (vec_level),
    .vec_start    (vec_start)
  );

  iav_read_mux #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_mux (
    .addr_odd   (addr_odd),
    .poll_arm   (poll_q),
    .rsel_irr   (rsel_q),
    .isr        (isr),
    .irr        (irr),
    .imr        (imr),
    .pend_valid (pend_valid),
    .pend_level (pend_level),
    .rd_byte    (rd_byte)
  );

  always_comb begin
    poll_n = poll_q;
    if (poll_take) poll_n = 1'b0;
    if (poll_cmd)  poll_n = 1'b1;

    rsel_n = rsel_we ? rsel_irr : rsel_q;

    oe_n   = oe_q;
    data_n = data_q;
    if (vec_start) begin
      oe_n   = 1'b1;
      data_n = {vec_base, vec_level};
    end else if (rd_go) begin
      oe_n   = 1'b1;
      data_n = rd_byte;
    end else if (rd_rise || ack_rise) begin
      oe_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
      rsel_q <= 1'b0;
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      poll_q <= poll_n;
      rsel_q <= rsel_n;
      oe_q   <= oe_n;
      data_q <= data_n;
    end
  end

  assign bus_oe   = oe_q;
  assign bus_data = data_q;

  // R8: enable drops once the read strobe has risen
  p_oe_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !ack_fall) |=> !bus_oe);

  // R8: enable only rises after a strobe fall
  p_oe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> ($past(ack_fall) || $past(rd_fall)));

  // R3: vector byte carries the programmed base in its upper bits
  p_vec_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_start |=> (bus_oe && bus_data[DATA_W-1:LVL_W] == $past(vec_base)));
endmodule

// File: tb/iav_ack_seq_test.sv
module iav_ack_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       inta_n, rd_n, addr_odd;
  logic       pend_valid;
  logic [2:0] pend_level;
  logic [4:0] vec_base;
  logic [7:0] isr, irr, imr;
  logic       rsel_we, rsel_irr, poll_cmd;
  logic       svc_commit;
  logic [2:0] svc_level;
  logic [7:0] bus_data;
  logic       bus_oe;

  always #4 clk = ~clk;

  iav_ack_seq uut (
    .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .rd_n(rd_n),
    .addr_odd(addr_odd), .pend_valid(pend_valid), .pend_level(pend_level),
    .vec_base(vec_base), .isr(isr), .irr(irr), .imr(imr),
    .rsel_we(rsel_we), .rsel_irr(rsel_irr), .poll_cmd(poll_cmd),
    .svc_commit(svc_commit), .svc_level(svc_level),
    .bus_data(bus_data), .bus_oe(bus_oe)
  );

  typedef struct {
    string      req;
    logic       oe;
    logic       commit;
    logic [2:0] lvl;
    logic [7:0] data;
    int         due;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations when their cycle arrives
  always @(negedge clk) begin
    exp_t e;
    bit   bad;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      e   = sbq.pop_front();
      bad = 1'b0;
      checks++;
      if (bus_oe !== e.oe) bad = 1'b1;
      if (e.oe && bus_data !== e.data) bad = 1'b1;
      if (svc_commit !== e.commit) bad = 1'b1;
      if (e.commit && svc_level !== e.lvl) bad = 1'b1;
      if (bad) begin
        failures++;
        $display("FAIL %s: oe=%b commit=%b lvl=%0d data=%02h expected oe=%b commit=%b lvl=%0d data=%02h",
                 e.req, bus_oe, svc_commit, svc_level, bus_data,
                 e.oe, e.commit, e.lvl, e.data);
      end
    end
  end

  task automatic expect_next(string req, logic oe, logic commit,
                             logic [2:0] lvl, logic [7:0] data);
    exp_t e;
    e.req = req; e.oe = oe; e.commit = commit; e.lvl = lvl;
    e.data = data; e.due = cyc + 1;
    sbq.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ack_low(string req, logic oe, logic commit,
                         logic [2:0] lvl, logic [7:0] data);
    inta_n = 1'b0;
    expect_next(req, oe, commit, lvl, data);
    step();
  endtask

  task automatic ack_high(string req);
    inta_n = 1'b1;
    expect_next(req, 1'b0, 1'b0, 3'd0, 8'h00);
    step();
  endtask

  task automatic rd_low(logic odd, string req, logic commit,
                        logic [2:0] lvl, logic [7:0] data);
    addr_odd = odd;
    rd_n = 1'b0;
    expect_next(req, 1'b1, commit, lvl, data);
    step();
  endtask

  task automatic rd_high(string req);
    rd_n = 1'b1;
    expect_next(req, 1'b0, 1'b0, 3'd0, 8'h00);
    step();
  endtask

  task automatic select_read(logic v);
    rsel_we = 1'b1; rsel_irr = v;
    step();
    rsel_we = 1'b0;
  endtask

  task automatic arm_poll();
    poll_cmd = 1'b1;
    step();
    poll_cmd = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; inta_n = 1'b1; rd_n = 1'b1; addr_odd = 1'b0;
    pend_valid = 1'b0; pend_level = 3'd0; vec_base = 5'h08;
    isr = 8'h24; irr = 8'h91; imr = 8'hC3;
    rsel_we = 1'b0; rsel_irr = 1'b0; poll_cmd = 1'b0;
    step(); step();
    expect_next("R1 reset state", 1'b0, 1'b0, 3'd0, 8'h00);
    step();
    rst_n = 1'b1;
    expect_next("R1 after release", 1'b0, 1'b0, 3'd0, 8'h00);
    step();

    // R1/R5: default read selection is the in-service register
    rd_low(1'b0, "R1 default even read isr", 1'b0, 3'd0, 8'h24);
    rd_high("R8 read release");

    // R2/R3: normal two-pulse handshake at level 5
    pend_valid = 1'b1; pend_level = 3'd5;
    ack_low("R2 first pulse commits", 1'b0, 1'b1, 3'd5, 8'h00);
    ack_high("R2 commit is one cycle");
    pend_level = 3'd2;
    ack_low("R3 second pulse vector", 1'b1, 1'b0, 3'd0, 8'h45);
    ack_high("R8 oe released after second pulse");

    // R9: count is idle again, a new pulse commits afresh
    pend_level = 3'd3; vec_base = 5'h1A;
    ack_low("R9 new first pulse after idle", 1'b0, 1'b1, 3'd3, 8'h00);
    ack_high("R9 first pulse release");
    ack_low("R3 second vector new base", 1'b1, 1'b0, 3'd0, 8'hD3);
    ack_high("R8 release");

    // R4: spurious acknowledge
    pend_valid = 1'b0;
    ack_low("R4 no commit when idle", 1'b0, 1'b0, 3'd0, 8'h00);
    ack_high("R4 release");
    pend_valid = 1'b1; pend_level = 3'd1;
    ack_low("R4 spurious vector", 1'b1, 1'b0, 3'd0, 8'hD7);
    ack_high("R4 release second");

    // R5: read select
    select_read(1'b1);
    rd_low(1'b0, "R5 even read irr", 1'b0, 3'd0, 8'h91);
    rd_high("R5 release");
    select_read(1'b0);
    rd_low(1'b0, "R5 even read isr", 1'b0, 3'd0, 8'h24);
    rd_high("R5 release isr");

    // R6/R7: poll, with an odd read in between leaving it armed
    pend_valid = 1'b1; pend_level = 3'd6;
    arm_poll();
    rd_low(1'b1, "R6 odd read imr", 1'b0, 3'd0, 8'hC3);
    rd_high("R6 release");
    rd_low(1'b0, "R7 poll read pending", 1'b1, 3'd6, 8'h86);
    rd_high("R7 poll release");
    rd_low(1'b0, "R7 poll cleared", 1'b0, 3'd0, 8'h24);
    rd_high("R7 release");
    pend_valid = 1'b0;
    arm_poll();
    rd_low(1'b0, "R7 poll none pending", 1'b0, 3'd0, 8'h00);
    rd_high("R7 none release");

    // R9: reset during the handshake returns the count to idle
    pend_valid = 1'b1; pend_level = 3'd4;
    ack_low("R9 pre-reset first pulse", 1'b0, 1'b1, 3'd4, 8'h00);
    ack_high("R9 pre-reset release");
    rst_n = 1'b0;
    expect_next("R1 reset mid handshake", 1'b0, 1'b0, 3'd0, 8'h00);
    step();
    rst_n = 1'b1;
    step();
    pend_level = 3'd0;
    ack_low("R9 pulse after reset is first", 1'b0, 1'b1, 3'd0, 8'h00);
    ack_high("R9 release");
    ack_low("R3 vector level 0", 1'b1, 1'b0, 3'd0, 8'hD0);
    ack_high("R8 final release");

    step(); step();
    done = 1'b1;
    report();
  end
endmodule